// File: doc/BRIEF.md
# Multi-Gain Converter Range Combiner

This block builds one wide signed sample per clock from three narrow sample streams. The three streams come from identical 8-bit converters that see the same analog signal through analog gains 24 dB apart. Path 0 has the highest gain, path 1 the middle gain and path 2 the lowest gain. Each code is two's complement. Because neighbouring paths overlap by four bits, a path that has hit its rail can be replaced by the next lower-gain path with no gap in resolution.

On each valid sample the block takes the highest-gain path that is neither at its rail nor in a hold-off window. Path 2 is the fallback and is always accepted. The block sign-extends the chosen code and shifts it to its weight in the 16-bit result. It then multiplies the aligned value by a per-path Q1.15 trim, which corrects gain mismatch between paths, and rounds and saturates the product. The result comes out with a path index.

Each of paths 0 and 1 has a small hold-off state machine with two states:
- ARMED: the path is usable.
- HOLD: the path is excluded while a counter runs down.

It has three transitions:
- ARMED to HOLD: a railed valid sample arrives while the programmed hold-off is non-zero. The counter loads the hold-off value.
- HOLD to HOLD (reload): another railed valid sample arrives during HOLD. The counter reloads.
- HOLD to ARMED: the counter reaches its last cycle without a new rail hit, or a rail hit arrives while the hold-off is zero.

A sticky flag reports that even the lowest-gain path was railed on a sample that was output.

Top module: `rc_combiner`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly 3 clock cycles. All paths share this latency.
- R2: A path code counts as railed only when it is 8'h7F (+127) or 8'h80 (-128). The codes 8'h7E and 8'h81 do not count as railed.
- R3: The path is chosen in priority order: path 0 if usable, otherwise path 1 if usable, otherwise path 2, which is always accepted even when railed. Path 0 or 1 is unusable for a valid sample that is railed.
- R4: The chosen code is sign-extended and shifted left by 0, 4 or 8 bits for paths 0, 1 and 2. With a trim of 16'h8000 the output equals that aligned value exactly.
- R5: `out_path` gives the index of the path that supplied each output sample: 0, 1 or 2.
- R6: After a railed valid sample on path 0 or 1, that path stays excluded for the next `holdoff` clock cycles. A further railed sample during the window restarts it.
- R7: With `holdoff` = 0, a path that railed is usable again on the very next sample.
- R8: The output is round(aligned × trim / 32768), with ties rounded toward +infinity. `gain_trim[p]` is unsigned Q1.15 and belongs to path p.
- R9: A trimmed result above 32767 is output as 16'h7FFF. A result below -32768 is output as 16'h8000.
- R10: `overload` is set in the cycle that `out_valid` presents a path 2 sample whose code was railed. It stays set until a cycle in which `ovl_clr` is high and no new event occurs. When both happen in the same cycle, the set wins.
- R11: During and right after reset, `out_valid`, `out_sample`, `out_path` and `overload` are 0, and both hold-off machines are ARMED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is present on all three paths |
| path_code | input | 3x8 | Two's-complement codes; index 0 is the highest gain |
| holdoff | input | 4 | Hold-off length in clock cycles, 0 to 15 |
| gain_trim | input | 3x16 | Per-path unsigned Q1.15 gain trim |
| ovl_clr | input | 1 | Clears the sticky overload flag |
| out_valid | output | 1 | Combined sample valid |
| out_sample | output | 16 | Combined, trimmed signed sample |
| out_path | output | 2 | Index of the path that supplied the sample |
| overload | output | 1 | Sticky: the lowest-gain path was railed |

## Verification
The hardest case to reach is a path that rails again while its hold-off window is still running. The reload has to extend the exclusion, and the visible effect shows up only several samples later on `out_path`. The stimulus streams back-to-back valid samples. It drives path 0 to +127 once and then to -128 two cycles later, holding path 0 in range otherwise. The bench then compares `out_path` for every sample of the stream against the window the requirement predicts. The same stream with hold-off 0 confirms recovery on the next sample.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam int RC_NPATH    = 3;
    localparam int RC_CODE_W   = 8;
    localparam int RC_STEP_SH  = 4;
    localparam int RC_HOLD_W   = 4;
    localparam int RC_TRIM_W   = 16;
    localparam int RC_TRIM_FRAC = 15;

    typedef enum logic [0:0] {
        HO_ARMED = 1'b0,
        HO_HOLD  = 1'b1
    } ho_state_e;

    // True when a two's-complement code sits on either rail
    function automatic logic code_is_rail(input logic [RC_CODE_W-1:0] c);
        logic [RC_CODE_W-1:0] pos_rail;
        logic [RC_CODE_W-1:0] neg_rail;
        pos_rail = {1'b0, {(RC_CODE_W-1){1'b1}}};
        neg_rail = {1'b1, {(RC_CODE_W-1){1'b0}}};
        return (c == pos_rail) || (c == neg_rail);
    endfunction

endpackage

// File: rtl/rc_holdoff.sv
module rc_holdoff
    import rc_pkg::*;
#(
    parameter int HOLD_W = RC_HOLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic              rail,
    input  logic [HOLD_W-1:0] holdoff,
    output logic              excluded
);

    ho_state_e         state, nxt_state;
    logic [HOLD_W-1:0] cnt, nxt_cnt;
    logic              hit;

    assign hit = sample_valid & rail;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HO_ARMED;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            HO_ARMED: begin
                if (hit && (holdoff != '0)) begin
                    nxt_state = HO_HOLD;
                    nxt_cnt   = holdoff;
                end
            end
            HO_HOLD: begin
                if (hit) begin
                    if (holdoff == '0) begin
                        nxt_state = HO_ARMED;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = holdoff;
                    end
                end else if (cnt <= HOLD_W'(1)) begin
                    nxt_state = HO_ARMED;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt - HOLD_W'(1);
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        excluded = hit || (state == HO_HOLD);
    end

endmodule

// File: rtl/rc_select.sv
module rc_select #(
    parameter int NPATH = 3,
    localparam int SEL_W = $clog2(NPATH)
) (
    input  logic [NPATH-1:0] usable,
    output logic [SEL_W-1:0] sel
);

    always_comb begin
        sel = SEL_W'(NPATH - 1);
        for (int i = NPATH - 2; i >= 0; i--) begin
            if (usable[i]) sel = SEL_W'(i);
        end
    end

endmodule

// File: rtl/rc_trim.sv
module rc_trim #(
    parameter int OUT_W  = 16,
    parameter int TRIM_W = 16,
    parameter int FRAC   = 15
) (
    input  logic [OUT_W-1:0]  din,
    input  logic [TRIM_W-1:0] trim,
    output logic [OUT_W-1:0]  dout
);

    localparam int PW = OUT_W + TRIM_W + 1;
    localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (OUT_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

    logic signed [PW-1:0] a_ext, t_ext, prod, rnd, scaled;

    always_comb begin
        a_ext  = {{(PW-OUT_W){din[OUT_W-1]}}, din};
        t_ext  = {{(PW-TRIM_W){1'b0}}, trim};
        prod   = a_ext * t_ext;
        rnd    = prod + HALF;
        scaled = rnd >>> FRAC;
        if (scaled > MAXV)      dout = MAXV[OUT_W-1:0];
        else if (scaled < MINV) dout = MINV[OUT_W-1:0];
        else                    dout = scaled[OUT_W-1:0];
    end

endmodule

// File: rtl/rc_combiner.sv
module rc_combiner
    import rc_pkg::*;
#(
    parameter int NPATH   = RC_NPATH,
    parameter int CODE_W  = RC_CODE_W,
    parameter int STEP_SH = RC_STEP_SH,
    parameter int HOLD_W  = RC_HOLD_W,
    parameter int TRIM_W  = RC_TRIM_W,
    localparam int OUT_W  = CODE_W + (NPATH - 1) * STEP_SH,
    localparam int SEL_W  = $clog2(NPATH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [NPATH-1:0][CODE_W-1:0]   path_code,
    input  logic [HOLD_W-1:0]              holdoff,
    input  logic [NPATH-1:0][TRIM_W-1:0]   gain_trim,
    input  logic                           ovl_clr,
    output logic                           out_valid,
    output logic [OUT_W-1:0]               out_sample,
    output logic [SEL_W-1:0]               out_path,
    output logic                           overload
);

    localparam int FRAC = TRIM_W - 1;

    // Rail detect and hold-off per sensitive path
    logic [NPATH-1:0] rail_w;
    logic [NPATH-2:0] excl_w;

    for (genvar g = 0; g < NPATH; g++) begin : g_rail
        assign rail_w[g] = code_is_rail(path_code[g]);
    end

    for (genvar g = 0; g < NPATH - 1; g++) begin : g_hold
        rc_holdoff #(.HOLD_W(HOLD_W)) u_ho (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_valid (in_valid),
            .rail         (rail_w[g]),
            .holdoff      (holdoff),
            .excluded     (excl_w[g])
        );
    end

    // Stage 1: capture codes and exclusion
    logic                         s1_valid;
    logic [NPATH-1:0][CODE_W-1:0] s1_code;
    logic [NPATH-1:0]             s1_excl;
    logic                         s1_top_rail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_code     <= '0;
            s1_excl     <= '0;
            s1_top_rail <= 1'b0;
        end else begin
            s1_valid    <= in_valid;
            s1_code     <= path_code;
            s1_excl     <= {1'b0, excl_w};
            s1_top_rail <= in_valid & rail_w[NPATH-1];
        end
    end

    // Stage 2: select and align
    logic [SEL_W-1:0]            sel_w;
    logic [NPATH-1:0][OUT_W-1:0] aligned_w;

    rc_select #(.NPATH(NPATH)) u_sel (
        .usable (~s1_excl),
        .sel    (sel_w)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_align
        assign aligned_w[g] =
            {{(OUT_W-CODE_W){s1_code[g][CODE_W-1]}}, s1_code[g]} << (g * STEP_SH);
    end

    logic              s2_valid;
    logic [OUT_W-1:0]  s2_aligned;
    logic [TRIM_W-1:0] s2_trim;
    logic [SEL_W-1:0]  s2_path;
    logic              s2_ovl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid   <= 1'b0;
            s2_aligned <= '0;
            s2_trim    <= '0;
            s2_path    <= '0;
            s2_ovl     <= 1'b0;
        end else begin
            s2_valid   <= s1_valid;
            s2_aligned <= aligned_w[sel_w];
            s2_trim    <= gain_trim[sel_w];
            s2_path    <= sel_w;
            s2_ovl     <= s1_valid & s1_top_rail & (sel_w == SEL_W'(NPATH - 1));
        end
    end

    // Stage 3: trim, round, saturate
    logic [OUT_W-1:0] trim_w;

    rc_trim #(.OUT_W(OUT_W), .TRIM_W(TRIM_W), .FRAC(FRAC)) u_trim (
        .din  (s2_aligned),
        .trim (s2_trim),
        .dout (trim_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
            out_path   <= '0;
            overload   <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_sample <= trim_w;
                out_path   <= s2_path;
            end
            if (s2_valid && s2_ovl) overload <= 1'b1;
            else if (ovl_clr)       overload <= 1'b0;
        end
    end

endmodule

// File: rtl/rc_combiner_chk.sv
module rc_combiner_chk
    import rc_pkg::*;
#(
    parameter int NPATH  = RC_NPATH,
    parameter int CODE_W = RC_CODE_W,
    localparam int SEL_W = $clog2(NPATH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CODE_W-1:0] code0,
    input logic              ovl_clr,
    input logic              out_valid,
    input logic [SEL_W-1:0]  out_path,
    input logic              overload
);

    logic [1:0] warm;
    logic [2:0] vhist;
    logic [2:0] rhist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm  <= '0;
            vhist <= '0;
            rhist <= '0;
        end else begin
            if (warm != 2'd3) warm <= warm + 2'd1;
            vhist <= {vhist[1:0], in_valid};
            rhist <= {rhist[1:0], in_valid & code_is_rail(code0)};
        end
    end

    // R1
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == vhist[2]));

    // R5
    path_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_path < SEL_W'(NPATH)));

    // R3
    rail_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && out_valid && rhist[2]) |-> (out_path != '0));

    // R10
    overload_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overload && !ovl_clr) |=> overload);

    // R10
    overload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_clr |=> (!overload || (out_valid && out_path == SEL_W'(NPATH - 1))));

endmodule

bind rc_combiner rc_combiner_chk #(.NPATH(NPATH), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .code0     (path_code[0]),
    .ovl_clr   (ovl_clr),
    .out_valid (out_valid),
    .out_path  (out_path),
    .overload  (overload)
);

// File: tb/tb_rc_combiner.sv
module tb_rc_combiner;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [2:0][7:0]   path_code = '0;
    logic [3:0]        holdoff = '0;
    logic [2:0][15:0]  gain_trim = {16'h8000, 16'h8000, 16'h8000};
    logic              ovl_clr = 1'b0;
    logic              out_valid;
    logic [15:0]       out_sample;
    logic [1:0]        out_path;
    logic              overload;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rc_combiner dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .path_code  (path_code),
        .holdoff    (holdoff),
        .gain_trim  (gain_trim),
        .ovl_clr    (ovl_clr),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_path   (out_path),
        .overload   (overload)
    );

    // {code0, code1, code2, expected path, expected sample}; trim unity, hold-off 0
    localparam logic [41:0] VEC [0:7] = '{
        {8'h10, 8'h01, 8'h00, 2'd0, 16'h0010},   // R3 path 0 in range
        {8'h7E, 8'h07, 8'h00, 2'd0, 16'h007E},   // R2 +126 not railed
        {8'h81, 8'hF8, 8'h00, 2'd0, 16'hFF81},   // R2 -127 not railed
        {8'h7F, 8'h08, 8'h00, 2'd1, 16'h0080},   // R4 path 1 shift 4
        {8'h80, 8'hF8, 8'h00, 2'd1, 16'hFF80},   // R2 -128 railed
        {8'h7F, 8'h7F, 8'h20, 2'd2, 16'h2000},   // R4 path 2 shift 8
        {8'h80, 8'h80, 8'hE0, 2'd2, 16'hE000},   // R3 fallback negative
        {8'h7F, 8'h7F, 8'h7F, 2'd2, 16'h7F00}    // R3 path 2 railed, accepted
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // One isolated sample; returns at the negedge after the output edge
    task automatic one_sample(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2);
        @(negedge clk);
        path_code = {c2, c1, c0};
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        @(negedge clk);
        check("R1 not yet valid", int'(out_valid), 0);
        @(negedge clk);
        check("R1 valid after 3", int'(out_valid), 1);
    endtask

    // Back-to-back stream of six samples; path 0 rails at k=0 and optionally at resat_k
    task automatic run_stream(input int hold, input int resat_k, input logic [5:0] exp_p1,
                              input string req);
        logic [1:0]  got_p [6];
        logic [15:0] got_s [6];
        holdoff = 4'(hold);
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                got_p[k-3] = out_path;
                got_s[k-3] = out_sample;
            end
            if (k == 0) begin
                path_code = {8'h00, 8'h05, 8'h7F};
                in_valid  = 1'b1;
            end else if (k < 6) begin
                path_code = {8'h00, 8'h01, (k == resat_k) ? 8'h80 : 8'h02};
                in_valid  = 1'b1;
            end else begin
                in_valid  = 1'b0;
            end
        end
        for (int k = 0; k < 6; k++) begin
            check(req, int'(got_p[k]), exp_p1[k] ? 1 : 0);
            check(req, int'(got_s[k]), exp_p1[k] ? ((k == 0) ? 80 : 16) : 2);
        end
        holdoff = 4'd0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        check("R11 out_valid", int'(out_valid), 0);
        check("R11 out_sample", int'(out_sample), 0);
        check("R11 out_path", int'(out_path), 0);
        check("R11 overload", int'(overload), 0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R10
        for (int i = 0; i < 8; i++) begin
            logic [41:0] v;
            v = VEC[i];
            if (i == 7) check("R10 clear before rail", int'(overload), 0);
            one_sample(v[41:34], v[33:26], v[25:18]);
            check("R3/R5 path", int'(out_path), int'(v[17:16]));
            check("R4 sample", int'(out_sample), int'(v[15:0]));
        end
        check("R10 set by railed path 2", int'(overload), 1);

        // R10 sticky, then clear
        one_sample(8'h05, 8'h00, 8'h00);
        check("R10 sticky", int'(overload), 1);
        @(negedge clk);
        ovl_clr = 1'b1;
        @(negedge clk);
        ovl_clr = 1'b0;
        check("R10 cleared", int'(overload), 0);

        // R6 hold-off window of 3 cycles
        run_stream(3, -1, 6'b001111, "R6 hold 3");
        // R6 rail again during the window restarts it
        run_stream(2, 2, 6'b011111, "R6 reload");
        // R7 no hold-off: immediate recovery
        run_stream(0, -1, 6'b000001, "R7 hold 0");

        // R8 trim with rounding
        gain_trim[0] = 16'h4000;
        one_sample(8'h03, 8'h00, 8'h00);
        check("R8 1.5 rounds up", int'(out_sample), 2);
        one_sample(8'hFD, 8'h00, 8'h00);
        check("R8 -1.5 rounds up", int'(out_sample), 16'hFFFF);
        gain_trim[0] = 16'hC000;
        one_sample(8'h10, 8'h00, 8'h00);
        check("R8 gain 1.5", int'(out_sample), 24);
        gain_trim[0] = 16'h8000;
        gain_trim[1] = 16'h4000;
        one_sample(8'h7F, 8'h09, 8'h00);
        check("R8 path 1 trim", int'(out_sample), 72);
        gain_trim[1] = 16'h8000;

        // R9 saturation of the trimmed result
        gain_trim[2] = 16'hFFFF;
        one_sample(8'h7F, 8'h7F, 8'h70);
        check("R9 positive clamp", int'(out_sample), 16'h7FFF);
        one_sample(8'h80, 8'h80, 8'h90);
        check("R9 negative clamp", int'(out_sample), 16'h8000);
        check("R10 no rail on path 2", int'(overload), 0);
        gain_trim[2] = 16'h8000;

        finish_up();
    end

endmodule